// File: doc/BRIEF.md
# External DMA Request Conditioner

This block sits between the external request pins of a DMA controller and the channel logic for channels 0 to 3. Each external request line is brought into the controller clock domain through a two-stage synchronizer. It is then detected in a way chosen per channel: low level, high level, rising edge or falling edge.

In the level modes the request follows the synchronized pin with no memory of its own. In the edge modes a detected edge sets a pending flag. The flag stays set until the channel reports that it has serviced a transfer.

Every serviced transfer returns a single-clock acknowledge strobe to the requesting device. Channels 4 and 5 have no external request and are not instantiated here. Arbitration between channels and the transfers themselves belong to other blocks.

Top module: `ext_dreq_cond`

## Requirements
- R1: The request input of every channel passes through two synchronizing flops. In a level mode, a change on `dreq_in` reaches `chan_req_o` after exactly two rising clock edges.
- R2: A channel's mode is written by pulsing its bit of `cfg_we` with the code on `cfg_mode`. The codes are 2'b00 low level, 2'b01 high level, 2'b10 rising edge and 2'b11 falling edge. The new mode takes effect from the following cycle.
- R3: Reset selects low-level detection on every channel. Reset also leaves `dev_ack_o` low. The synchronizers reset to the inactive high state, so no request appears until a pin is seen low.
- R4: In the low-level mode, `chan_req_o` is the inverse of the synchronized input. In the high-level mode it equals the synchronized input. Neither level mode latches anything.
- R5: In the rising-edge mode, a 0-to-1 change of the synchronized input sets a pending request. The pending request stays asserted on `chan_req_o` whatever the pin does afterwards, until it is cleared.
- R6: In the falling-edge mode, a 1-to-0 change of the synchronized input sets the pending request in the same way.
- R7: A `chan_ack_i` pulse while a pending request is set clears it from the next cycle. If a new edge is detected in the same cycle as the acknowledge, the request stays pending.
- R8: A mode write whose code differs from the current mode clears that channel's pending request. A write of the same code leaves the pending request untouched.
- R9: `dev_ack_o` pulses for one cycle, one clock after each cycle in which `chan_ack_i` and `chan_req_o` are both high on that channel. It stays low after an acknowledge given with no request present.
- R10: The channels are independent. Stimulus on one channel has no effect on the outputs of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dreq_in | input | NUM_CH | Raw external request pins, one per channel |
| cfg_we | input | NUM_CH | Per-channel mode write strobe |
| cfg_mode | input | 2 | Mode code written to the strobed channels |
| chan_ack_i | input | NUM_CH | Channel reports a serviced transfer |
| chan_req_o | output | NUM_CH | Conditioned request to each channel |
| dev_ack_o | output | NUM_CH | Single-clock acknowledge strobe to the device |

## Verification
The assertions assume that the channel raises `chan_ack_i` only in cycles where it means to retire a transfer. They also assume that `cfg_mode` is valid in any cycle where a `cfg_we` bit is high. The level-mode properties start only once the checker's own copy of the input history covers the synchronizer depth after reset. The stimulus changes inputs half a period away from the sampling edge, so the two-edge latency is never ambiguous. Its random phase asserts acknowledges freely, including with no request present, which both the design and the model must treat as a no-op.

// File: rtl/ext_dreq_pkg.sv
package ext_dreq_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_mode_e;
endpackage

// File: rtl/ext_dreq_sync.sv
module ext_dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  // resets to the idle-high state so the default low-level mode sees no request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ext_dreq_chan.sv
module ext_dreq_chan
  import ext_dreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       chan_ack,
  output logic       req,
  output logic       dev_ack,
  output logic [1:0] mode_o
);
  det_mode_e mode_q, mode_d;
  logic prev_q, pend_q, pend_d, ack_q, ack_d;
  logic hit, mode_chg;

  always_comb begin
    unique case (mode_q)
      DET_LOW:  req = ~sync_in;
      DET_HIGH: req = sync_in;
      default:  req = pend_q;
    endcase
  end

  always_comb begin
    unique case (mode_q)
      DET_RISE: hit = sync_in & ~prev_q;
      DET_FALL: hit = ~sync_in & prev_q;
      default:  hit = 1'b0;
    endcase
    mode_chg = cfg_we && (cfg_mode != mode_q);
    mode_d   = cfg_we ? det_mode_e'(cfg_mode) : mode_q;
    if (mode_chg)      pend_d = 1'b0;
    else if (hit)      pend_d = 1'b1;
    else if (chan_ack) pend_d = 1'b0;
    else               pend_d = pend_q;
    ack_d = chan_ack & req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DET_LOW;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (cfg_we) mode_q <= mode_d;
      prev_q <= sync_in;
      pend_q <= pend_d;
      ack_q  <= ack_d;
    end
  end

  assign dev_ack = ack_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/ext_dreq_cond.sv
module ext_dreq_cond #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] dreq_in,
  input  logic [NUM_CH-1:0] cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [NUM_CH-1:0] chan_ack_i,
  output logic [NUM_CH-1:0] chan_req_o,
  output logic [NUM_CH-1:0] dev_ack_o
);
  logic [NUM_CH-1:0]      sync_vec;
  logic [NUM_CH-1:0][1:0] mode_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ext_dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (dreq_in[c]),
      .q (sync_vec[c])
    );
    ext_dreq_chan u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (sync_vec[c]),
      .cfg_we   (cfg_we[c]),
      .cfg_mode (cfg_mode),
      .chan_ack (chan_ack_i[c]),
      .req      (chan_req_o[c]),
      .dev_ack  (dev_ack_o[c]),
      .mode_o   (mode_vec[c])
    );
  end
endmodule

// File: rtl/ext_dreq_cond_chk.sv
module ext_dreq_cond_chk #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH-1:0]      dreq_in,
  input logic [NUM_CH-1:0]      cfg_we,
  input logic [1:0]             cfg_mode,
  input logic [NUM_CH-1:0]      chan_ack_i,
  input logic [NUM_CH-1:0]      chan_req_o,
  input logic [NUM_CH-1:0]      dev_ack_o,
  input logic [NUM_CH-1:0][1:0] mode_vec
);
  localparam int CW = $clog2(SYNC_STAGES + 2);
  logic [SYNC_STAGES-1:0][NUM_CH-1:0] hist_q;
  logic [CW-1:0] warm_cnt;
  logic warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= '0;
    else if (warm_cnt < CW'(SYNC_STAGES)) warm_cnt <= warm_cnt + 1'b1;
  end
  assign warm = (warm_cnt >= CW'(SYNC_STAGES));

  always_ff @(posedge clk) begin
    hist_q[0] <= dreq_in;
    for (int k = 1; k < SYNC_STAGES; k++) hist_q[k] <= hist_q[k-1];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_default_r3: assert (mode_vec == '0 && dev_ack_o == '0);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    p_level_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && mode_vec[i] == 2'b00) |-> chan_req_o[i] == !hist_q[SYNC_STAGES-1][i]);
    p_level_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && mode_vec[i] == 2'b01) |-> chan_req_o[i] == hist_q[SYNC_STAGES-1][i]);
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[i][1] && chan_req_o[i] && !chan_ack_i[i] && !cfg_we[i]) |=> chan_req_o[i]);
    p_mode_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we[i] |=> mode_vec[i] == $past(cfg_mode));
    p_change_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we[i] && cfg_mode != mode_vec[i] && cfg_mode[1]) |=> !chan_req_o[i]);
    p_ack_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack_o[i] |-> $past(chan_req_o[i] && chan_ack_i[i]));
  end
endmodule

bind ext_dreq_cond ext_dreq_cond_chk #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dreq_in    (dreq_in),
  .cfg_we     (cfg_we),
  .cfg_mode   (cfg_mode),
  .chan_ack_i (chan_ack_i),
  .chan_req_o (chan_req_o),
  .dev_ack_o  (dev_ack_o),
  .mode_vec   (mode_vec)
);

// File: tb/ext_dreq_cond_test.sv
`timescale 1ns/1ps
module ext_dreq_cond_test;
  localparam int N = 4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [N-1:0] dreq, we, cack;
  logic [1:0] cmode;
  logic [N-1:0] creq, dack;

  int checks = 0;
  int fails = 0;
  string tag = "R3";

  int m_s1[N], m_s2[N], m_prv[N], m_md[N], m_pd[N], m_ak[N];

  ext_dreq_cond #(.NUM_CH(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .dreq_in(dreq), .cfg_we(we), .cfg_mode(cmode),
    .chan_ack_i(cack), .chan_req_o(creq), .dev_ack_o(dack)
  );

  function automatic int m_req(int c);
    case (m_md[c])
      0:       return (m_s2[c] == 0) ? 1 : 0;
      1:       return m_s2[c];
      default: return m_pd[c];
    endcase
  endfunction

  task automatic m_reset();
    for (int c = 0; c < N; c++) begin
      m_s1[c] = 1; m_s2[c] = 1; m_prv[c] = 1;
      m_md[c] = 0; m_pd[c] = 0; m_ak[c] = 0;
    end
  endtask

  task automatic m_step();
    for (int c = 0; c < N; c++) begin
      int r, hit;
      r = m_req(c);
      hit = 0;
      if (m_md[c] == 2 && m_s2[c] == 1 && m_prv[c] == 0) hit = 1;
      if (m_md[c] == 3 && m_s2[c] == 0 && m_prv[c] == 1) hit = 1;
      if (we[c] && int'(cmode) != m_md[c]) m_pd[c] = 0;
      else if (hit == 1)                  m_pd[c] = 1;
      else if (cack[c])                   m_pd[c] = 0;
      m_ak[c] = (cack[c] && r == 1) ? 1 : 0;
      if (we[c]) m_md[c] = int'(cmode);
      m_prv[c] = m_s2[c];
      m_s2[c]  = m_s1[c];
      m_s1[c]  = int'(dreq[c]);
    end
  endtask

  task automatic compare();
    for (int c = 0; c < N; c++) begin
      checks++;
      if (int'(creq[c]) != m_req(c)) begin
        fails++;
        $display("FAIL %s ch%0d chan_req_o actual %b expected %0d", tag, c, creq[c], m_req(c));
      end
      checks++;
      if (int'(dack[c]) != m_ak[c]) begin
        fails++;
        $display("FAIL %s ch%0d dev_ack_o actual %b expected %0d", tag, c, dack[c], m_ak[c]);
      end
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      if (!rst_n) m_reset(); else m_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic set_mode(int c, logic [1:0] md);
    we = '0; we[c] = 1'b1; cmode = md;
    step(1);
    we = '0;
  endtask

  task automatic ack(int c);
    cack[c] = 1'b1;
    step(1);
    cack[c] = 1'b0;
  endtask

  initial begin
    #(200000 * 5.0);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dreq = '1; we = '0; cack = '0; cmode = 2'b00;
    m_reset();
    tag = "R3"; step(3);
    rst_n = 1'b1;
    step(4);
    // R1: low pin on ch0 seen two edges later
    tag = "R1"; dreq[0] = 1'b0; step(3);
    dreq[0] = 1'b1; step(3);
    // R4: high-level mode on ch1, no latching
    tag = "R2"; set_mode(1, 2'b01); step(2);
    tag = "R4";
    dreq[1] = 1'b0; step(3); dreq[1] = 1'b1; step(1); dreq[1] = 1'b0; step(4);
    // R5: rising edge on ch2 latched until acknowledged
    tag = "R5"; set_mode(2, 2'b10);
    dreq[2] = 1'b0; step(4); dreq[2] = 1'b1; step(5); dreq[2] = 1'b0; step(4);
    tag = "R9"; ack(2); step(3);
    // R6: falling edge on ch3
    tag = "R6"; set_mode(3, 2'b11); step(3);
    dreq[3] = 1'b0; step(5); dreq[3] = 1'b1; step(4);
    tag = "R7"; ack(3); step(2);
    // R7: acknowledges around a fresh edge on ch2
    tag = "R7";
    dreq[2] = 1'b1; step(2); dreq[2] = 1'b0; step(3);
    dreq[2] = 1'b1; cack[2] = 1'b1; step(5); cack[2] = 1'b0; step(3);
    // R8: same-code write keeps pending, different code clears it
    tag = "R8";
    dreq[2] = 1'b0; step(3); dreq[2] = 1'b1; step(4);
    set_mode(2, 2'b10); step(2);
    set_mode(2, 2'b11); step(3);
    set_mode(2, 2'b10); step(2);
    // R9: acknowledge without request gives no strobe; continuous level acks
    tag = "R9";
    ack(0); step(2);
    dreq[0] = 1'b0; step(3);
    cack[0] = 1'b1; step(3); cack[0] = 1'b0; step(2);
    dreq[0] = 1'b1; step(3);
    // R10: random mixed traffic on all channels
    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      dreq = N'($urandom);
      cack = N'($urandom) & N'($urandom);
      if ($urandom_range(0, 9) == 0) begin
        we = N'($urandom);
        cmode = 2'($urandom);
      end else begin
        we = '0;
      end
      step(1);
    end
    we = '0; cack = '0;
    step(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule